// File: doc/BRIEF.md
# Flash Configuration Shadow Loader

This block runs once at flash power-up. After a start pulse it walks a fixed parameter table of nonvolatile configuration locations in ascending index order. For each location it issues one read request and waits for the returned word and its ECC status. It then copies the word into a volatile shadow register that the rest of the flash controller reads.

Each table entry is either a system entry or a user entry. System entries hold configuration, redundancy and firmware settings. User entries hold protection, censorship and bus-interface settings. An uncorrectable error on a system entry stops initialization immediately and raises a fatal flag. An uncorrectable error on a user entry loads all ones into that shadow register and the walk goes on. In that case initialization still finishes, but the program/erase-good status stays low.

The read channel is split into a request stream and a response stream, each using valid/ready. The request stays valid with a stable address until the memory side accepts it. The response is accepted only while the loader waits for data. Only one read is ever in flight, so back-pressure on either side simply stretches the walk. Start, done, fatal and good are plain level signals.

Top module: `cfg_shadow_loader`

## Requirements
- R1: While reset is held and after it is released, `init_done`, `init_fatal`, `pe_good` and `rd_req_valid` are low and every shadow word is zero.
- R2: A `start` pulse in the idle state begins the walk. Entries are requested in ascending index order, and each request carries that entry's table address (default table: 0x10, 0x14, 0x18, 0x20, 0x24, 0x28; entries 0 to 2 are system entries, 3 to 5 are user entries).
- R3: Once raised, `rd_req_valid` stays high with a stable `rd_req_addr` until `rd_req_ready` is seen. `rd_rsp_ready` is never high while a request is pending, and no shadow word changes while a request waits.
- R4: A response with ECC code 2'b00 (clean) or 2'b01 (single-bit corrected) stores `rd_rsp_data` unchanged into the shadow word of the current entry.
- R5: A response with ECC code 2'b10 or 2'b11 (uncorrectable) on a system entry raises `init_fatal` and keeps `init_done` low. No further request is issued, and the shadow words of that entry and of all later entries stay zero.
- R6: An uncorrectable response on a user entry stores all ones into that entry's shadow word, and the walk continues with the next entry.
- R7: After the last entry is written, `init_done` goes high. `pe_good` is high exactly when no user entry failed. Done, fatal and good hold until reset, and a `start` pulse in the done or fatal state has no effect.
- R8: Each entry takes one request cycle, the response wait and one write cycle. With `rd_req_ready` held high and every response arriving one cycle after acceptance, `init_done` rises 18 clock edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins initialization when the block is idle |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory side accepts the request |
| rd_req_addr | output | ADDR_W | Address of the location being read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Loader accepts the response |
| rd_rsp_data | input | DATA_W | Word read from the location |
| rd_rsp_ecc | input | 2 | ECC status: 00 clean, 01 corrected, 1x uncorrectable |
| shadow_flat | output | NUM_ENTRIES*DATA_W | Shadow words, entry 0 in the low bits |
| init_done | output | 1 | Initialization finished normally |
| init_fatal | output | 1 | Initialization aborted on a system entry |
| pe_good | output | 1 | Program/erase-good status |

## Verification
A shadow word changes on the edge after the response handshake, and done follows on the edge after the last write. The bench therefore does not assume fixed delays. It waits for done or fatal, with a bounded cycle count, and then compares every flag and shadow word at the falling edge. The 18-edge figure is checked separately, on a run with no stalls and a one-cycle responder. In the back-pressure test the request is held unaccepted for several cycles, and its address and the shadow words are sampled while it waits.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_READ,
    ST_WAIT_DATA,
    ST_WRITE_SHADOW,
    ST_DONE,
    ST_FATAL
  } ldr_state_t;

  localparam logic [1:0] ECC_CLEAN = 2'b00;
  localparam logic [1:0] ECC_FIXED = 2'b01;
  localparam logic [1:0] ECC_DOUBLE = 2'b10;
  localparam logic [1:0] ECC_BAD_X = 2'b11;

endpackage

// File: rtl/cfg_shadow_table.sv
module cfg_shadow_table #(
  parameter int NUM_ENTRIES = 6,
  parameter int ADDR_W = 8,
  parameter int IDX_W = 3,
  parameter logic [NUM_ENTRIES*ADDR_W-1:0] ENTRY_ADDR = '0,
  parameter logic [NUM_ENTRIES-1:0] ENTRY_SYS = '0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              entry_sys
);
  localparam int SLOTS = 2 ** IDX_W;

  logic [ADDR_W-1:0] addr_tbl [SLOTS];
  logic [SLOTS-1:0]  sys_tbl;

  // Unused slots above NUM_ENTRIES read as zero.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_ENTRIES) begin : g_real
      assign addr_tbl[g] = ENTRY_ADDR[g*ADDR_W +: ADDR_W];
      assign sys_tbl[g]  = ENTRY_SYS[g];
    end else begin : g_pad
      assign addr_tbl[g] = '0;
      assign sys_tbl[g]  = 1'b0;
    end
  end

  assign entry_addr = addr_tbl[idx];
  assign entry_sys  = sys_tbl[idx];
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
  parameter int NUM_ENTRIES = 6,
  parameter int DATA_W = 32,
  parameter int IDX_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_ENTRIES*DATA_W-1:0] shadow_flat
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        word_q <= wr_data;
    end
    assign shadow_flat[g*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/cfg_shadow_fsm.sv
module cfg_shadow_fsm
  import cfg_shadow_pkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  parameter int DATA_W = 32,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              entry_sys,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [1:0]        rsp_ecc,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic              fatal,
  output logic              pe_good
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  ldr_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] hold_q;
  logic              user_fail_q;
  logic              uncorr;

  assign uncorr = (rsp_ecc == ECC_DOUBLE) || (rsp_ecc == ECC_BAD_X);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      hold_q      <= '0;
      user_fail_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q     <= ST_ISSUE_READ;
          idx_q       <= '0;
          user_fail_q <= 1'b0;
        end
        ST_ISSUE_READ: if (req_ready) state_q <= ST_WAIT_DATA;
        ST_WAIT_DATA: if (rsp_valid) begin
          if (uncorr && entry_sys) begin
            state_q <= ST_FATAL;
          end else if (uncorr) begin
            hold_q      <= '1;
            user_fail_q <= 1'b1;
            state_q     <= ST_WRITE_SHADOW;
          end else begin
            hold_q  <= rsp_data;
            state_q <= ST_WRITE_SHADOW;
          end
        end
        ST_WRITE_SHADOW: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_ISSUE_READ;
          end
        end
        ST_DONE:  state_q <= ST_DONE;
        ST_FATAL: state_q <= ST_FATAL;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx       = idx_q;
  assign req_valid = (state_q == ST_ISSUE_READ);
  assign rsp_ready = (state_q == ST_WAIT_DATA);
  assign wr_en     = (state_q == ST_WRITE_SHADOW);
  assign wr_data   = hold_q;
  assign done      = (state_q == ST_DONE);
  assign fatal     = (state_q == ST_FATAL);
  assign pe_good   = (state_q == ST_DONE) && !user_fail_q;
endmodule

// File: rtl/cfg_shadow_loader.sv
module cfg_shadow_loader #(
  parameter int NUM_ENTRIES = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [NUM_ENTRIES*ADDR_W-1:0] ENTRY_ADDR =
    {8'h28, 8'h24, 8'h20, 8'h18, 8'h14, 8'h10},
  parameter logic [NUM_ENTRIES-1:0] ENTRY_SYS = 6'b000111
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic                          rd_req_valid,
  input  logic                          rd_req_ready,
  output logic [ADDR_W-1:0]             rd_req_addr,
  input  logic                          rd_rsp_valid,
  output logic                          rd_rsp_ready,
  input  logic [DATA_W-1:0]             rd_rsp_data,
  input  logic [1:0]                    rd_rsp_ecc,
  output logic [NUM_ENTRIES*DATA_W-1:0] shadow_flat,
  output logic                          init_done,
  output logic                          init_fatal,
  output logic                          pe_good
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [IDX_W-1:0]  cur_idx;
  logic              cur_sys;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;

  cfg_shadow_table #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .ENTRY_ADDR(ENTRY_ADDR), .ENTRY_SYS(ENTRY_SYS)
  ) u_table (
    .idx(cur_idx), .entry_addr(rd_req_addr), .entry_sys(cur_sys)
  );

  cfg_shadow_fsm #(
    .NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .entry_sys(cur_sys),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready),
    .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready),
    .rsp_data(rd_rsp_data), .rsp_ecc(rd_rsp_ecc),
    .idx(cur_idx), .wr_en(wr_en), .wr_data(wr_data),
    .done(init_done), .fatal(init_fatal), .pe_good(pe_good)
  );

  cfg_shadow_bank #(
    .NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(cur_idx),
    .wr_data(wr_data), .shadow_flat(shadow_flat)
  );
endmodule

// File: rtl/cfg_shadow_loader_chk.sv
module cfg_shadow_loader_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_ready,
  input logic [1:0]        rd_rsp_ecc,
  input logic              init_done,
  input logic              init_fatal,
  input logic              pe_good
);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !rd_rsp_ready);

  a_r5_fatal_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_fatal) |-> $past(rd_rsp_valid && rd_rsp_ready && rd_rsp_ecc[1]));

  a_r5_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_fatal |=> init_fatal && !init_done && !rd_req_valid);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done && $stable(pe_good) && !init_fatal);

  a_r7_good_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    pe_good |-> init_done);
endmodule

bind cfg_shadow_loader cfg_shadow_loader_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cfg_shadow_loader_bench.sv
module cfg_shadow_loader_bench;
  localparam int N = 6;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [7:0] TB_ADDR [N] = '{8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28};
  localparam logic [N-1:0] TB_SYS = 6'b000111;
  // Vector: {ecc codes (entry i at bits 2i+1:2i), expected fatal, expected good}
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {12'h000, 1'b0, 1'b1},  // all clean
    {12'h555, 1'b0, 1'b1},  // all corrected
    {12'h200, 1'b0, 1'b0},  // user entry 4 uncorrectable
    {12'h008, 1'b1, 1'b0},  // system entry 1 uncorrectable
    {12'h801, 1'b0, 1'b0},  // entry 0 corrected, user 5 uncorrectable
    {12'h003, 1'b1, 1'b0},  // system entry 0 code 11
    {12'hA80, 1'b0, 1'b0},  // every user entry uncorrectable
    {12'h0A0, 1'b1, 1'b0}   // system 2 fails before user 3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [AW-1:0] rd_req_addr;
  logic [DW-1:0] rd_rsp_data;
  logic [1:0] rd_rsp_ecc;
  logic [N*DW-1:0] shadow_flat;
  logic init_done, init_fatal, pe_good;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int resp_lat = 1;
  logic req_rdy = 1'b1;
  logic [1:0] ecc_map [256];
  logic [7:0] seq_log [16];
  int seq_n = 0;
  int cd = 0;
  logic [7:0] paddr;

  always #4 clk = ~clk;

  assign rd_req_ready = req_rdy;

  cfg_shadow_loader u_cfg_shadow_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_ecc(rd_rsp_ecc), .shadow_flat(shadow_flat),
    .init_done(init_done), .init_fatal(init_fatal), .pe_good(pe_good)
  );

  function automatic logic [DW-1:0] data_of(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, 8'hC3};
  endfunction

  // Memory-side responder: answers resp_lat cycles after acceptance.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      rd_rsp_ecc   <= 2'b00;
      cd           <= 0;
      paddr        <= '0;
    end else begin
      if (rd_rsp_valid && rd_rsp_ready) rd_rsp_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        if (seq_n < 16) seq_log[seq_n] <= rd_req_addr;
        seq_n <= seq_n + 1;
        paddr <= rd_req_addr;
        if (resp_lat <= 1) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= data_of(rd_req_addr);
          rd_rsp_ecc   <= ecc_map[rd_req_addr];
        end else cd <= resp_lat - 1;
      end else if (cd != 0) begin
        cd <= cd - 1;
        if (cd == 1) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= data_of(paddr);
          rd_rsp_ecc   <= ecc_map[paddr];
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    seq_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_ecc(input logic [11:0] codes);
    for (int a = 0; a < 256; a++) ecc_map[a] = 2'b00;
    for (int i = 0; i < N; i++) ecc_map[TB_ADDR[i]] = codes[2*i +: 2];
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 400; k++) begin
      if (init_done || init_fatal) break;
      @(negedge clk);
    end
  endtask

  task automatic check_outcome(input logic [11:0] codes, input logic ef, input logic eg);
    logic stop = 1'b0;
    logic [DW-1:0] exp;
    check("R5/R7 fatal flag", {31'd0, init_fatal}, {31'd0, ef});
    check("R5/R7 done flag", {31'd0, init_done}, {31'd0, !ef});
    check("R7 pe_good", {31'd0, pe_good}, {31'd0, eg});
    for (int i = 0; i < N; i++) begin
      if (stop) exp = '0;
      else if (codes[2*i+1] && TB_SYS[i]) begin
        exp = '0;
        stop = 1'b1;
      end else if (codes[2*i+1]) exp = '1;
      else exp = data_of(TB_ADDR[i]);
      check(codes[2*i+1] ? (TB_SYS[i] ? "R5 shadow" : "R6 shadow") : "R4 shadow",
            shadow_flat[i*DW +: DW], exp);
    end
  endtask

  initial begin
    int n;
    req_rdy = 1'b1;
    resp_lat = 1;
    load_ecc(12'h000);

    // R1: reset state, sampled while reset is held and after release
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 done in reset", {31'd0, init_done}, 32'd0);
    check("R1 fatal in reset", {31'd0, init_fatal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 good after reset", {31'd0, pe_good}, 32'd0);
    check("R1 req_valid after reset", {31'd0, rd_req_valid}, 32'd0);
    for (int i = 0; i < N; i++)
      check("R1 shadow zero", shadow_flat[i*DW +: DW], '0);

    // Vector table for R4, R5, R6, R7
    for (int v = 0; v < NV; v++) begin
      do_reset();
      load_ecc(VEC[v][13:2]);
      pulse_start();
      wait_end();
      check_outcome(VEC[v][13:2], VEC[v][1], VEC[v][0]);
    end

    // R8 latency and R2 ordering on a stall-free run
    do_reset();
    load_ecc(12'h000);
    pulse_start();
    n = 0;
    while (!init_done && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R8 edges from start to done", n, 18);
    check("R2 request count", seq_n, N);
    for (int i = 0; i < N; i++)
      check("R2 request order", {24'd0, seq_log[i]}, {24'd0, TB_ADDR[i]});

    // R7: start in done state has no effect
    pulse_start();
    repeat (4) @(negedge clk);
    check("R7 no request after done", {31'd0, rd_req_valid}, 32'd0);
    check("R7 done held", {31'd0, init_done}, 32'd1);
    check("R7 request count unchanged", seq_n, N);

    // R5: after a fatal stop, start has no effect and no request follows
    do_reset();
    load_ecc(12'h008);
    pulse_start();
    wait_end();
    pulse_start();
    repeat (4) @(negedge clk);
    check("R5 requests stop at fatal entry", seq_n, 2);
    check("R5 fatal held", {31'd0, init_fatal}, 32'd1);

    // R3: back-pressure on the request, then a slow responder
    do_reset();
    load_ecc(12'h000);
    req_rdy = 1'b0;
    resp_lat = 3;
    pulse_start();
    repeat (5) begin
      @(negedge clk);
      check("R3 request held", {31'd0, rd_req_valid}, 32'd1);
      check("R3 address stable", {24'd0, rd_req_addr}, {24'd0, TB_ADDR[0]});
      check("R3 no response ready", {31'd0, rd_rsp_ready}, 32'd0);
      check("R3 shadow untouched", shadow_flat[DW-1:0], '0);
    end
    req_rdy = 1'b1;
    wait_end();
    check_outcome(12'h000, 1'b0, 1'b1);
    resp_lat = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule